// File: doc/BRIEF.md
# PLL Control Register Interlock Block

This block holds the software-visible configuration and status for a clock-generation PLL. It has two byte-wide registers on a single-cycle synchronous bus. The control register carries the PLL enable, the base-clock select, the prescaler exponent P and the VCO range exponent E. The bandwidth register carries the automatic/manual bandwidth mode, the live lock flag and the acquisition/tracking bit.

Writes are filtered by interlocks between the fields, so software cannot reconfigure or deselect the PLL unsafely while it runs. Every interlock decision uses the register contents held before the current write. As a result, moving from the PLL-off state to the PLL clock takes two writes: the first turns the PLL on and the second selects its output. Field values drive the PLL control outputs directly from flops.

Top module: `pll_ctrl_regs`

## Requirements
- R1: After reset every stored field is 0, so reading either register returns 8'h00 while lock_i is 0.
- R2: Control register layout: bit 5 = enable, bit 4 = clock select, bits 3:2 = P, bits 1:0 = E, and bits 7:6 read 0. A control write cannot clear the enable bit while the select bit is set; such a write leaves the enable bit at 1.
- R3: The select bit becomes 1 only if the enable bit was 1 before the write and is still 1 after it. A single write of 8'h30 from the off state sets only the enable bit.
- R4: Writes to P (bits 3:2) take effect only when the enable bit was 0 before the write. Otherwise P keeps its value.
- R5: Writes to E (bits 1:0) take effect only when the enable bit was 0 before the write and the written value is not 3. Otherwise E keeps its value, so E never holds 3.
- R6: Bandwidth register layout: bit 7 = automatic mode (1 = automatic, read/write), bit 6 = live lock_i (writes ignored), bit 5 = acquisition bit, and bits 4:0 always read 0.
- R7: While the automatic bit was 1 before a write, writes to bit 5 are ignored and bit 5 reads back the live acq_i.
- R8: While the automatic bit was 0 before a write, bit 5 stores the written value, drives acq_force_o and is returned on readback.
- R9: Reads from any address other than the two register addresses return 8'h00.
- R10: pll_en_o, clk_sel_o, pre_o, vrs_o, auto_o and acq_force_o always equal the stored field values, and they change only on the clock edge of an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| lock_i | input | 1 | Lock indication from the PLL |
| acq_i | input | 1 | Acquisition indication from the PLL |
| pll_en_o | output | 1 | PLL enable |
| clk_sel_o | output | 1 | Select PLL output as base clock |
| pre_o | output | 2 | Prescaler exponent P |
| vrs_o | output | 2 | VCO range exponent E |
| auto_o | output | 1 | Automatic bandwidth mode |
| acq_force_o | output | 1 | Forced acquisition value for manual mode |

## Verification
The hardest situations to reach are the ones where an interlock depends on the previous contents of a register. Examples are a write that tries to clear the enable bit while the select bit is set, and a bandwidth write that leaves automatic mode while also writing the acquisition bit, which must be ignored because the old mode was automatic. Directed sequences walk the registers through off, on, selected and back to off, and through each mode change of the bandwidth register. A few hundred seeded random writes then follow, and their data often carries both bits at once. A bench model computes the expected readback and output values.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;
  localparam int REG_W = 8;

  // control register bit positions
  localparam int CTRL_EN_BIT  = 5;
  localparam int CTRL_SEL_BIT = 4;
  localparam int CTRL_PRE_LSB = 2;
  localparam int CTRL_VRS_LSB = 0;

  // bandwidth register bit positions
  localparam int BW_AUTO_BIT = 7;
  localparam int BW_LOCK_BIT = 6;
  localparam int BW_ACQ_BIT  = 5;

  localparam logic [1:0] VRS_ILLEGAL = 2'd3;

  typedef struct packed {
    logic       en;
    logic       sel;
    logic [1:0] pre;
    logic [1:0] vrs;
  } ctrl_t;

  typedef struct packed {
    logic auto_mode;
    logic acq;
  } bw_t;
endpackage

// File: rtl/pll_ctrl_field.sv
module pll_ctrl_field
  import pll_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output ctrl_t            q_o
);
  ctrl_t q, d;

  always_comb begin
    d = q;
    if (wr_i) begin
      // enable is held while select is set (old value)
      d.en  = wdata_i[CTRL_EN_BIT] | q.sel;
      // select needs enable both before and after the write
      d.sel = wdata_i[CTRL_SEL_BIT] & q.en & d.en;
      if (!q.en) begin
        d.pre = wdata_i[CTRL_PRE_LSB +: 2];
        if (wdata_i[CTRL_VRS_LSB +: 2] != VRS_ILLEGAL)
          d.vrs = wdata_i[CTRL_VRS_LSB +: 2];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign q_o = q;
endmodule

// File: rtl/pll_bw_field.sv
module pll_bw_field
  import pll_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output bw_t              q_o
);
  bw_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (wr_i) begin
      q.auto_mode <= wdata_i[BW_AUTO_BIT];
      // forced value only writable from manual mode
      if (!q.auto_mode) q.acq <= wdata_i[BW_ACQ_BIT];
    end
  end

  assign q_o = q;
endmodule

// File: rtl/pll_rd_mux.sv
module pll_rd_mux
  import pll_ctrl_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] BW_ADDR   = 8'h11
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  ctrl_t             ctrl_i,
  input  bw_t               bw_i,
  input  logic              lock_i,
  input  logic              acq_i,
  output logic [REG_W-1:0]  rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_ADDR) begin
      rdata_o[CTRL_EN_BIT]        = ctrl_i.en;
      rdata_o[CTRL_SEL_BIT]       = ctrl_i.sel;
      rdata_o[CTRL_PRE_LSB +: 2]  = ctrl_i.pre;
      rdata_o[CTRL_VRS_LSB +: 2]  = ctrl_i.vrs;
    end else if (addr_i == BW_ADDR) begin
      rdata_o[BW_AUTO_BIT] = bw_i.auto_mode;
      rdata_o[BW_LOCK_BIT] = lock_i;
      rdata_o[BW_ACQ_BIT]  = bw_i.auto_mode ? acq_i : bw_i.acq;
    end
  end
endmodule

// File: rtl/pll_ctrl_regs.sv
module pll_ctrl_regs
  import pll_ctrl_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] BW_ADDR   = 8'h11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              lock_i,
  input  logic              acq_i,
  output logic              pll_en_o,
  output logic              clk_sel_o,
  output logic [1:0]        pre_o,
  output logic [1:0]        vrs_o,
  output logic              auto_o,
  output logic              acq_force_o
);
  ctrl_t ctrl_q;
  bw_t   bw_q;
  logic  ctrl_wr, bw_wr;

  assign ctrl_wr = we_i && (addr_i == CTRL_ADDR);
  assign bw_wr   = we_i && (addr_i == BW_ADDR);

  pll_ctrl_field i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctrl_wr),
    .wdata_i (wdata_i),
    .q_o     (ctrl_q)
  );

  pll_bw_field i_bw (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (bw_wr),
    .wdata_i (wdata_i),
    .q_o     (bw_q)
  );

  pll_rd_mux #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .BW_ADDR   (BW_ADDR)
  ) i_rd (
    .addr_i  (addr_i),
    .ctrl_i  (ctrl_q),
    .bw_i    (bw_q),
    .lock_i  (lock_i),
    .acq_i   (acq_i),
    .rdata_o (rdata_o)
  );

  assign pll_en_o    = ctrl_q.en;
  assign clk_sel_o   = ctrl_q.sel;
  assign pre_o       = ctrl_q.pre;
  assign vrs_o       = ctrl_q.vrs;
  assign auto_o      = bw_q.auto_mode;
  assign acq_force_o = bw_q.acq;
endmodule

// File: rtl/pll_ctrl_regs_chk.sv
module pll_ctrl_regs_chk #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] BW_ADDR   = 8'h11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [7:0]        rdata_o,
  input logic              lock_i,
  input logic              acq_i,
  input logic              pll_en_o,
  input logic              clk_sel_o,
  input logic [1:0]        pre_o,
  input logic [1:0]        vrs_o,
  input logic              auto_o,
  input logic              acq_force_o
);
  p_en_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_sel_o |=> pll_en_o);

  p_sel_needs_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_sel_o |-> pll_en_o);

  p_sel_from_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_en_o |=> !clk_sel_o);

  p_pre_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_en_o |=> $stable(pre_o));

  p_vrs_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_en_o |=> $stable(vrs_o));

  p_vrs_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vrs_o != 2'd3);

  p_bw_layout_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == BW_ADDR) |-> (rdata_o[4:0] == 5'd0 && rdata_o[6] == lock_i
                             && rdata_o[7] == auto_o));

  p_acq_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_o |=> $stable(acq_force_o));

  p_acq_live_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == BW_ADDR && auto_o) |-> rdata_o[5] == acq_i);

  p_acq_forced_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == BW_ADDR && !auto_o) |-> rdata_o[5] == acq_force_o);

  p_unmapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != CTRL_ADDR && addr_i != BW_ADDR) |-> rdata_o == 8'h00);

  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable({pll_en_o, clk_sel_o, pre_o, vrs_o, auto_o, acq_force_o}));
endmodule

bind pll_ctrl_regs pll_ctrl_regs_chk #(
  .ADDR_W    (ADDR_W),
  .CTRL_ADDR (CTRL_ADDR),
  .BW_ADDR   (BW_ADDR)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .we_i        (we_i),
  .rdata_o     (rdata_o),
  .lock_i      (lock_i),
  .acq_i       (acq_i),
  .pll_en_o    (pll_en_o),
  .clk_sel_o   (clk_sel_o),
  .pre_o       (pre_o),
  .vrs_o       (vrs_o),
  .auto_o      (auto_o),
  .acq_force_o (acq_force_o)
);

// File: tb/test_pll_ctrl_regs.sv
`timescale 1ns/1ps
module test_pll_ctrl_regs;
  localparam logic [7:0] CA = 8'h10;
  localparam logic [7:0] BA = 8'h11;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       lock = 1'b0, acq = 1'b0;
  logic       pll_en, clk_sel, auto_m, acq_force;
  logic [1:0] pre, vrs;

  int n_chk = 0, n_fail = 0;

  // bench model
  logic m_en = 0, m_sel = 0, m_auto = 0, m_acq = 0;
  logic [1:0] m_pre = 0, m_vrs = 0;

  always #2.5 clk = ~clk;

  pll_ctrl_regs i_pll_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .lock_i(lock), .acq_i(acq), .pll_en_o(pll_en),
    .clk_sel_o(clk_sel), .pre_o(pre), .vrs_o(vrs), .auto_o(auto_m),
    .acq_force_o(acq_force)
  );

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    logic [7:0] r = 8'h00;
    if (a == CA) r = {2'b00, m_en, m_sel, m_pre, m_vrs};
    else if (a == BA) r = {m_auto, lock, (m_auto ? acq : m_acq), 5'b0};
    return r;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    logic n_en;
    if (a == CA) begin
      n_en = d[5] | m_sel;
      m_sel = d[4] & m_en & n_en;
      if (!m_en) begin
        m_pre = d[3:2];
        if (d[1:0] != 2'd3) m_vrs = d[1:0];
      end
      m_en = n_en;
    end else if (a == BA) begin
      if (!m_auto) m_acq = d[5];
      m_auto = d[7];
    end
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    addr = a;
    #1 check(tag, rdata, exp_read(a));
  endtask

  task automatic chk_out(input string tag);
    check(tag, {pll_en, clk_sel, pre, vrs, auto_m, acq_force},
          {m_en, m_sel, m_pre, m_vrs, m_auto, m_acq});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    rd("R1 ctrl after reset", CA);
    rd("R1 bw after reset", BA);
    chk_out("R1 outputs after reset");

    wr(CA, 8'h30);  rd("R3 one write from off sets only enable", CA);
    wr(CA, 8'h30);  rd("R3 second write sets select", CA);
    wr(CA, 8'h00);  rd("R2 enable held while select set", CA);
    wr(CA, 8'h2E);  rd("R4 R5 P and E frozen while enabled", CA);
    wr(CA, 8'h10);  rd("R3 select blocked as enable clears", CA);
    wr(CA, 8'h0E);  rd("R4 P written while off", CA);
    wr(CA, 8'h07);  rd("R5 E of 3 rejected", CA);
    chk_out("R10 outputs follow control fields");

    lock = 1'b1; acq = 1'b1;
    wr(BA, 8'hFF);  rd("R6 bw layout, auto set", BA);
    acq = 1'b0;     rd("R7 live acq in auto mode", BA);
    wr(BA, 8'h80);  chk_out("R7 acq write ignored in auto");
    wr(BA, 8'h00);  rd("R8 leaving auto keeps stored acq", BA);
    wr(BA, 8'h20);  rd("R8 manual acq stored", BA);
    chk_out("R8 acq_force_o follows stored value");
    wr(BA, 8'h1F);  rd("R6 low bits read zero", BA);
    rd("R9 unmapped reads zero", 8'h55);
    wr(8'h55, 8'hFF); chk_out("R9 unmapped write no effect");

    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, d;
      int s = $urandom_range(0, 9);
      a = (s < 4) ? CA : (s < 8) ? BA : 8'($urandom);
      d = 8'($urandom);
      lock = 1'($urandom); acq = 1'($urandom);
      wr(a, d);
      rd("R2 R3 R4 R5 random ctrl", CA);
      rd("R6 R7 R8 random bw", BA);
      chk_out("R10 random outputs");
    end
    finish_run();
  end
endmodule